// File: doc/BRIEF.md
# Operand Forwarding and Hazard Interlock

This block drives the hazard control of a six-stage in-order scalar pipeline whose stages are fetch, decode, register read, execute (ALU), memory and writeback. Every cycle it takes the two source register numbers of the instruction in the register-read stage and compares them with the destination numbers of the writers now in the ALU and MEM stages. From those comparisons it picks, for each operand, which value the operand mux should pass on: the register file, the ALU-stage result or the MEM-stage result.

A source that depends on a load still in the ALU stage cannot be forwarded, because the load data does not exist until MEM finishes. In that case the block holds the fetch, decode and register-read stages and injects a bubble into the ALU stage for that cycle. When a branch in the ALU stage resolves as mispredicted, the block marks the three younger in-flight instructions as nops and asserts a fetch redirect. A flush overrides any stall raised in the same cycle. All outputs are combinational functions of the current inputs. The clock and reset are used only to sample the built-in checks.

Top module: `hzd_fwd_unit`

## Requirements
- R1: A valid register-read instruction whose source equals a nonzero ALU-stage destination, where the ALU stage writes a register, gets select 2'b01 (ALU result) for that operand.
- R2: A source that matches only the MEM-stage writer's nonzero destination gets select 2'b10 (MEM result).
- R3: When both the ALU and MEM writers match the same source, the ALU select 2'b01 wins.
- R4: Register 0 never matches. A stage whose write-valid bit is low never matches. With no match the select is 2'b00 (register file), and a load to register 0 raises no stall.
- R5: When either source matches a load in the ALU stage, hold_if, hold_id, hold_rd and bubble_alu are all 1 in that cycle. The operand select still points at the ALU stage.
- R6: A match against the MEM-stage writer, including a load, is served by forwarding and never raises a hold or a bubble.
- R7: A mispredict indication sets kill_if, kill_id, kill_rd and redirect to 1 in the same cycle.
- R8: When a mispredict and a load-use hazard occur together, the kills and the redirect are 1 while all holds and bubble_alu are 0.
- R9: When the register-read stage holds no valid instruction, both selects are 2'b00 and no hold or bubble is raised.
- R10: With no dependence and no mispredict, every hold, bubble, kill and redirect output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the built-in checks |
| rst_n | input | 1 | Synchronous active-low reset, gates the checks |
| rd_valid | input | 1 | Register-read stage holds a real instruction |
| rd_src1 | input | AW | First source register number |
| rd_src2 | input | AW | Second source register number |
| alu_wr | input | 1 | ALU-stage instruction writes a register |
| alu_dst | input | AW | ALU-stage destination register |
| alu_load | input | 1 | ALU-stage instruction is a load |
| mem_wr | input | 1 | MEM-stage instruction writes a register |
| mem_dst | input | AW | MEM-stage destination register |
| br_mispredict | input | 1 | Branch in the ALU stage resolved against its prediction |
| fwd_sel1 | output | 2 | Operand 1 source: 00 regfile, 01 ALU, 10 MEM |
| fwd_sel2 | output | 2 | Operand 2 source, same encoding |
| hold_if | output | 1 | Fetch stage keeps its content |
| hold_id | output | 1 | Decode stage keeps its content |
| hold_rd | output | 1 | Register-read stage keeps its content |
| bubble_alu | output | 1 | Insert a nop into the ALU stage |
| kill_if | output | 1 | Turn the fetch-stage instruction into a nop |
| kill_id | output | 1 | Turn the decode-stage instruction into a nop |
| kill_rd | output | 1 | Turn the register-read instruction into a nop |
| redirect | output | 1 | Restart fetch at the corrected target |

## Verification
A wrong comparison or a wrong priority shows up on fwd_sel1 or fwd_sel2 in the same cycle as the offending operands, because nothing here is registered. A broken load-use or flush decision shows up at once on the hold, bubble, kill and redirect outputs. Each vector sets up one stage occupancy and reads every output before the next edge, so a fault can be traced to the exact input pattern that exposed it. The register-0 case, the invalid-stage case and the case where flush and stall occur together are covered explicitly, since those are where a missing gate would go unnoticed in normal traffic.

// File: rtl/hzd_pkg.sv
// Package: shared encoding of the operand source select.
// Assumes the datapath operand mux decodes exactly these three values.
package hzd_pkg;
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_ALU     = 2'b01,
        SRC_MEM     = 2'b10
    } fwd_src_e;
endpackage

// File: rtl/hzd_src_match.sv
// Module: compares one source register against the ALU and MEM writers.
// It picks the forwarding source and flags a load-use dependence.
// Assumes register 0 is hard-wired to zero and is never forwarded.
module hzd_src_match
    import hzd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_valid,
    input  logic [AW-1:0] src,
    input  logic          alu_wr,
    input  logic [AW-1:0] alu_dst,
    input  logic          alu_load,
    input  logic          mem_wr,
    input  logic [AW-1:0] mem_dst,
    output fwd_src_e      sel,
    output logic          load_hit
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic src_live;
    logic hit_alu;
    logic hit_mem;

    // Decide whether each later stage holds the producer of this source.
    always_comb begin
        src_live = rd_valid && (src != ZERO_REG);
        hit_alu  = src_live && alu_wr && (alu_dst == src);
        hit_mem  = src_live && mem_wr && (mem_dst == src);
    end

    // Pick the youngest matching producer; a load in ALU cannot be served yet.
    always_comb begin
        if (hit_alu)      sel = SRC_ALU;
        else if (hit_mem) sel = SRC_MEM;
        else              sel = SRC_REGFILE;
        load_hit = hit_alu && alu_load;
    end

    AST_ZERO_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (src == ZERO_REG) |-> (sel == SRC_REGFILE && !load_hit)); // R4
    AST_LOAD_FROM_ALU: assert property (@(posedge clk) disable iff (!rst_n)
        load_hit |-> (sel == SRC_ALU)); // R5
    AST_IDLE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (sel == SRC_REGFILE)); // R9
endmodule

// File: rtl/hzd_ctl.sv
// Module: turns load-use hits and a mispredict into stage holds, bubble,
// kills and redirect. Assumes the mispredicting branch sits in the ALU stage,
// so the fetch, decode and register-read stages hold younger work.
module hzd_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic load_hit1,
    input  logic load_hit2,
    input  logic mispredict,
    output logic hold_if,
    output logic hold_id,
    output logic hold_rd,
    output logic bubble_alu,
    output logic kill_if,
    output logic kill_id,
    output logic kill_rd,
    output logic redirect
);
    logic stall_req;

    // Interlock unless a flush is discarding the stalled instruction anyway.
    always_comb begin
        stall_req  = (load_hit1 || load_hit2) && !mispredict;
        hold_if    = stall_req;
        hold_id    = stall_req;
        hold_rd    = stall_req;
        bubble_alu = stall_req;
    end

    // Squash speculative younger instructions and steer fetch.
    always_comb begin
        kill_if  = mispredict;
        kill_id  = mispredict;
        kill_rd  = mispredict;
        redirect = mispredict;
    end

    AST_FLUSH_OVER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> (!hold_rd && !hold_id && !hold_if && !bubble_alu)); // R8
    AST_HOLD_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rd |-> (hold_id && hold_if && bubble_alu)); // R5
    AST_REDIRECT_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (kill_if && kill_id && kill_rd)); // R7
endmodule

// File: rtl/hzd_fwd_unit.sv
// Module: hazard control top for a six-stage in-order pipeline. It holds one
// comparator per source operand and the shared stall/flush control.
// Assumes the MEM-stage result, load data included, is ready to forward.
module hzd_fwd_unit
    import hzd_pkg::*;
#(
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_src1,
    input  logic [AW-1:0] rd_src2,
    input  logic          alu_wr,
    input  logic [AW-1:0] alu_dst,
    input  logic          alu_load,
    input  logic          mem_wr,
    input  logic [AW-1:0] mem_dst,
    input  logic          br_mispredict,
    output logic [1:0]    fwd_sel1,
    output logic [1:0]    fwd_sel2,
    output logic          hold_if,
    output logic          hold_id,
    output logic          hold_rd,
    output logic          bubble_alu,
    output logic          kill_if,
    output logic          kill_id,
    output logic          kill_rd,
    output logic          redirect
);
    localparam int NSRC = 2;

    logic [AW-1:0] srcs      [NSRC];
    fwd_src_e      sels      [NSRC];
    logic [NSRC-1:0] load_hits;

    // Gather the operand numbers so one comparator is built per source.
    always_comb begin
        srcs[0] = rd_src1;
        srcs[1] = rd_src2;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hzd_src_match #(.AW(AW)) u_match (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_valid (rd_valid),
            .src      (srcs[g]),
            .alu_wr   (alu_wr),
            .alu_dst  (alu_dst),
            .alu_load (alu_load),
            .mem_wr   (mem_wr),
            .mem_dst  (mem_dst),
            .sel      (sels[g]),
            .load_hit (load_hits[g])
        );
    end

    // Present the selects as plain vectors at the boundary.
    always_comb begin
        fwd_sel1 = sels[0];
        fwd_sel2 = sels[1];
    end

    hzd_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_hit1  (load_hits[0]),
        .load_hit2  (load_hits[1]),
        .mispredict (br_mispredict),
        .hold_if    (hold_if),
        .hold_id    (hold_id),
        .hold_rd    (hold_rd),
        .bubble_alu (bubble_alu),
        .kill_if    (kill_if),
        .kill_id    (kill_id),
        .kill_rd    (kill_rd),
        .redirect   (redirect)
    );

    AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rd |-> (alu_load && alu_wr && rd_valid)); // R6
    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel1 != 2'b11) && (fwd_sel2 != 2'b11)); // R3
endmodule

// File: tb/hzd_fwd_unit_tb.sv
module hzd_fwd_unit_tb;
    typedef struct packed {
        logic       rdv;
        logic [4:0] s1;
        logic [4:0] s2;
        logic       aw;
        logic [4:0] ad;
        logic       ald;
        logic       mw;
        logic [4:0] md;
        logic       mis;
        logic [1:0] e1;
        logic [1:0] e2;
        logic       est;
        logic       efl;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1,5'd1,5'd2, 1'b1,5'd3,1'b0, 1'b1,5'd4, 1'b0, 2'd0,2'd0,1'b0,1'b0, 4'd10}, // R10
        '{1'b1,5'd3,5'd2, 1'b1,5'd3,1'b0, 1'b1,5'd4, 1'b0, 2'd1,2'd0,1'b0,1'b0, 4'd1},  // R1
        '{1'b1,5'd1,5'd3, 1'b1,5'd3,1'b0, 1'b1,5'd4, 1'b0, 2'd0,2'd1,1'b0,1'b0, 4'd1},  // R1
        '{1'b1,5'd4,5'd2, 1'b1,5'd3,1'b0, 1'b1,5'd4, 1'b0, 2'd2,2'd0,1'b0,1'b0, 4'd2},  // R2
        '{1'b1,5'd4,5'd4, 1'b1,5'd3,1'b0, 1'b1,5'd4, 1'b0, 2'd2,2'd2,1'b0,1'b0, 4'd2},  // R2
        '{1'b1,5'd5,5'd5, 1'b1,5'd5,1'b0, 1'b1,5'd5, 1'b0, 2'd1,2'd1,1'b0,1'b0, 4'd3},  // R3
        '{1'b1,5'd5,5'd6, 1'b1,5'd5,1'b0, 1'b1,5'd6, 1'b0, 2'd1,2'd2,1'b0,1'b0, 4'd3},  // R3
        '{1'b1,5'd0,5'd0, 1'b1,5'd0,1'b0, 1'b1,5'd0, 1'b0, 2'd0,2'd0,1'b0,1'b0, 4'd4},  // R4
        '{1'b1,5'd7,5'd8, 1'b0,5'd7,1'b0, 1'b0,5'd8, 1'b0, 2'd0,2'd0,1'b0,1'b0, 4'd4},  // R4
        '{1'b1,5'd0,5'd3, 1'b1,5'd0,1'b1, 1'b0,5'd0, 1'b0, 2'd0,2'd0,1'b0,1'b0, 4'd4},  // R4
        '{1'b1,5'd9,5'd1, 1'b1,5'd9,1'b1, 1'b0,5'd0, 1'b0, 2'd1,2'd0,1'b1,1'b0, 4'd5},  // R5
        '{1'b1,5'd2,5'd9, 1'b1,5'd9,1'b1, 1'b1,5'd2, 1'b0, 2'd2,2'd1,1'b1,1'b0, 4'd5},  // R5
        '{1'b1,5'd9,5'd9, 1'b0,5'd0,1'b0, 1'b1,5'd9, 1'b0, 2'd2,2'd2,1'b0,1'b0, 4'd6},  // R6
        '{1'b1,5'd1,5'd2, 1'b1,5'd3,1'b0, 1'b1,5'd4, 1'b1, 2'd0,2'd0,1'b0,1'b1, 4'd7},  // R7
        '{1'b1,5'd9,5'd1, 1'b1,5'd9,1'b1, 1'b0,5'd0, 1'b1, 2'd1,2'd0,1'b0,1'b1, 4'd8},  // R8
        '{1'b0,5'd9,5'd9, 1'b1,5'd9,1'b1, 1'b1,5'd9, 1'b0, 2'd0,2'd0,1'b0,1'b0, 4'd9}   // R9
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_valid = 1'b0;
    logic [4:0] rd_src1 = '0;
    logic [4:0] rd_src2 = '0;
    logic       alu_wr = 1'b0;
    logic [4:0] alu_dst = '0;
    logic       alu_load = 1'b0;
    logic       mem_wr = 1'b0;
    logic [4:0] mem_dst = '0;
    logic       br_mispredict = 1'b0;
    logic [1:0] fwd_sel1, fwd_sel2;
    logic hold_if, hold_id, hold_rd, bubble_alu;
    logic kill_if, kill_id, kill_rd, redirect;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hzd_fwd_unit u_dut (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid),
        .rd_src1(rd_src1), .rd_src2(rd_src2),
        .alu_wr(alu_wr), .alu_dst(alu_dst), .alu_load(alu_load),
        .mem_wr(mem_wr), .mem_dst(mem_dst), .br_mispredict(br_mispredict),
        .fwd_sel1(fwd_sel1), .fwd_sel2(fwd_sel2),
        .hold_if(hold_if), .hold_id(hold_id), .hold_rd(hold_rd),
        .bubble_alu(bubble_alu), .kill_if(kill_if), .kill_id(kill_id),
        .kill_rd(kill_rd), .redirect(redirect)
    );

    task automatic check(input int req, input logic [1:0] e1, input logic [1:0] e2,
                         input logic est, input logic efl);
        logic [11:0] got, exp;
        got = {fwd_sel1, fwd_sel2, hold_if, hold_id, hold_rd, bubble_alu,
               kill_if, kill_id, kill_rd, redirect};
        exp = {e1, e2, est, est, est, est, efl, efl, efl, efl};
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d got=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        rd_valid = v.rdv; rd_src1 = v.s1; rd_src2 = v.s2;
        alu_wr = v.aw; alu_dst = v.ad; alu_load = v.ald;
        mem_wr = v.mw; mem_dst = v.md; br_mispredict = v.mis;
        #5;
        check(int'(v.req), v.e1, v.e2, v.est, v.efl);
    endtask

    initial begin
        // reset state: idle inputs give idle controls (R10)
        repeat (2) @(posedge clk);
        #5 check(10, 2'd0, 2'd0, 1'b0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < NV; i++) apply(VEC[i]);
        // R5 then R6: load advances from ALU to MEM, stall clears, MEM forwards
        apply('{1'b1,5'd12,5'd12, 1'b1,5'd12,1'b1, 1'b0,5'd0, 1'b0, 2'd1,2'd1,1'b1,1'b0, 4'd5});
        apply('{1'b1,5'd12,5'd12, 1'b0,5'd0,1'b0, 1'b1,5'd12, 1'b0, 2'd2,2'd2,1'b0,1'b0, 4'd6});
        // R4: ALU writer disabled but MEM matches highest register
        apply('{1'b1,5'd31,5'd0, 1'b0,5'd31,1'b1, 1'b1,5'd31, 1'b0, 2'd2,2'd0,1'b0,1'b0, 4'd4});
        // R8: flush with load-use on second source
        apply('{1'b1,5'd3,5'd17, 1'b1,5'd17,1'b1, 1'b1,5'd3, 1'b1, 2'd2,2'd1,1'b0,1'b1, 4'd8});
        // R10: back to quiet after flush
        apply(VEC[0]);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule